// File: doc/BRIEF.md
# Bounded-Window Sequence Monitor

This block watches three sampled signals and enforces one temporal rule: once a start condition is accepted, a response signal must appear somewhere inside a window that opens a minimum number of cycles later and closes a maximum number of cycles later. From the cycle in which the response is seen, a follow-up signal must be present exactly a fixed number of cycles later. Any violation produces a single-cycle failure pulse. The complementary ok flag is high whenever no failure is being reported.

The start condition is built from a cause input and a lead input, and parameters choose which of the two take part. When both are used they are ANDed. When neither is used, the monitor arms itself in every idle cycle. The monitor tracks one attempt at a time. It uses a small state register and a single down-counter that is reloaded at each phase, so a wide window costs only counter bits and no extra states. A mute input or a synchronous reset abandons the current attempt.

Top module: `win_monitor`

## Requirements
- R1: After a synchronous reset (`rst_i` high at a clock edge), `fail_o` is 0 and `ok_o` is 1 until a violation is reported.
- R2: With both start inputs enabled (the defaults), an attempt is accepted only when `cause_i` and `lead_i` are both 1 at the same edge while the monitor is idle. Either input alone does not start an attempt.
- R3: For an attempt accepted at edge t, `hit_i` is sampled at edges t+MIN_DLY through t+MAX_DLY. The first edge at which it is 1 ends the window. A `hit_i` pulse before t+MIN_DLY has no effect.
- R4: If `hit_i` is 0 at every edge of the window, `fail_o` is 1 for the cycle that follows edge t+MAX_DLY.
- R5: If `hit_i` matched at edge h, `tail_i` is sampled only at edge h+TAIL_DLY. A value of 1 ends the attempt with no failure. A value of 0 raises `fail_o` for the cycle after that edge.
- R6: With MIN_DLY equal to MAX_DLY, the monitor behaves as a fixed delay. `hit_i` must be 1 at exactly edge t+MIN_DLY, and otherwise the failure is reported after that same edge.
- R7: Start conditions that arrive while an attempt is in progress are ignored. Once an attempt has ended, a new start condition is accepted again.
- R8: `mute_i` high at an edge returns the monitor to idle with no failure reported, so no pulse arises later from the abandoned attempt. A `rst_i` pulse in the middle of an attempt has the same effect.
- R9: `fail_o` never stays high for two consecutive cycles, and `ok_o` is always its inverse.
- R10: The counter width is derived from the parameters at elaboration, and the counter never holds a value greater than the largest value it is loaded with. Legal parameters are MIN_DLY >= 1, MAX_DLY >= MIN_DLY and TAIL_DLY >= 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| mute_i | input | 1 | Abandon the current attempt and hold the monitor idle |
| cause_i | input | 1 | Start condition, first term |
| lead_i | input | 1 | Start condition, second term |
| hit_i | input | 1 | Response expected inside the window |
| tail_i | input | 1 | Follow-up expected TAIL_DLY cycles after the response |
| fail_o | output | 1 | One-cycle pulse on a rule violation |
| ok_o | output | 1 | Inverse of fail_o |

## Verification
A corrupted state or counter value shows up directly as a misplaced failure pulse. If the window is off by one, the pulse moves one edge earlier or later, or a response on the boundary edge is wrongly rejected. If the busy state is lost, a second start condition produces an extra pulse MAX_DLY cycles after it. Both errors appear within MAX_DLY + TAIL_DLY cycles of the start. The bench therefore records the exact edge of every pulse and checks the timing on two configurations: a true window and a degenerate fixed delay. It drives the response at every offset from the start edge to past the window's end, with the follow-up both present and absent.

// File: rtl/win_pkg.sv
package win_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WAIT  = 3'd1,
        S_RANGE = 3'd2,
        S_FIX   = 3'd3,
        S_TAIL  = 3'd4
    } win_state_e;

    function automatic int win_max3(input int a, input int b, input int c);
        int r;
        r = a;
        if (b > r) r = b;
        if (c > r) r = c;
        return r;
    endfunction

    function automatic int win_cnt_width(input int m, input int n, input int k);
        return $clog2(win_max3(m, n - m + 1, k)) + 1;
    endfunction

endpackage

// File: rtl/win_trigger.sv
module win_trigger #(
    parameter bit USE_CAUSE = 1'b1,
    parameter bit USE_LEAD  = 1'b1
) (
    input  logic cause_i,
    input  logic lead_i,
    output logic fire_o
);

    logic cause_term;
    logic lead_term;

    generate
        if (USE_CAUSE) begin : g_cause
            assign cause_term = cause_i;
        end else begin : g_no_cause
            assign cause_term = 1'b1;
        end
        if (USE_LEAD) begin : g_lead
            assign lead_term = lead_i;
        end else begin : g_no_lead
            assign lead_term = 1'b1;
        end
    endgenerate

    assign fire_o = cause_term & lead_term;

endmodule

// File: rtl/win_fsm.sv
module win_fsm
    import win_pkg::*;
#(
    parameter int MIN_DLY  = 2,
    parameter int MAX_DLY  = 4,
    parameter int TAIL_DLY = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mute_i,
    input  logic fire_i,
    input  logic hit_i,
    input  logic tail_i,
    output logic fail_o
);

    localparam int CW      = win_cnt_width(MIN_DLY, MAX_DLY, TAIL_DLY);
    localparam int LD_WAIT = (MIN_DLY >= 2) ? MIN_DLY - 2 : 0;
    localparam int SPAN    = MAX_DLY - MIN_DLY;
    localparam int LD_FIX  = (TAIL_DLY >= 2) ? TAIL_DLY - 2 : 0;
    localparam int CNT_TOP = win_max3(LD_WAIT, SPAN, LD_FIX);
    localparam bit SKIP_WAIT = (MIN_DLY == 1);
    localparam bit SKIP_FIX  = (TAIL_DLY == 1);

    win_state_e     st_q;
    logic [CW-1:0]  cnt_q;
    logic           fail_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || mute_i) begin
            st_q   <= S_IDLE;
            cnt_q  <= '0;
            fail_q <= 1'b0;
        end else begin
            fail_q <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (fire_i) begin
                        if (SKIP_WAIT) begin
                            st_q  <= S_RANGE;
                            cnt_q <= CW'(SPAN);
                        end else begin
                            st_q  <= S_WAIT;
                            cnt_q <= CW'(LD_WAIT);
                        end
                    end
                end
                S_WAIT: begin
                    if (cnt_q == '0) begin
                        st_q  <= S_RANGE;
                        cnt_q <= CW'(SPAN);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                S_RANGE: begin
                    if (hit_i) begin
                        if (SKIP_FIX) begin
                            st_q  <= S_TAIL;
                            cnt_q <= '0;
                        end else begin
                            st_q  <= S_FIX;
                            cnt_q <= CW'(LD_FIX);
                        end
                    end else if (cnt_q == '0) begin
                        fail_q <= 1'b1;
                        st_q   <= S_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                S_FIX: begin
                    if (cnt_q == '0) begin
                        st_q <= S_TAIL;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                S_TAIL: begin
                    if (!tail_i) fail_q <= 1'b1;
                    st_q  <= S_IDLE;
                    cnt_q <= '0;
                end
                default: begin
                    st_q  <= S_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign fail_o = fail_q;

    // R4 / R5: a failure only follows the window check or the tail check
    a_r4_fail_source: assert property (@(posedge clk_i) disable iff (rst_i)
        fail_q |-> ($past(st_q) == S_RANGE || $past(st_q) == S_TAIL));

    // R8: mute abandons the attempt and suppresses the report
    a_r8_mute_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        mute_i |=> (st_q == S_IDLE && !fail_q));

    // R9: failure is a single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        fail_q |=> !fail_q);

    // R10: counter stays within its largest load value
    a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        32'(cnt_q) <= CNT_TOP);

    // R3: a miss inside the window with time left retries one edge later
    a_r3_retry: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == S_RANGE && !hit_i && cnt_q != '0 && !mute_i)
        |=> (st_q == S_RANGE && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/win_monitor.sv
module win_monitor #(
    parameter int MIN_DLY   = 2,
    parameter int MAX_DLY   = 4,
    parameter int TAIL_DLY  = 2,
    parameter bit USE_CAUSE = 1'b1,
    parameter bit USE_LEAD  = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mute_i,
    input  logic cause_i,
    input  logic lead_i,
    input  logic hit_i,
    input  logic tail_i,
    output logic fail_o,
    output logic ok_o
);

    logic fire;
    logic fail;

    win_trigger #(
        .USE_CAUSE(USE_CAUSE),
        .USE_LEAD (USE_LEAD)
    ) u_trigger (
        .cause_i(cause_i),
        .lead_i (lead_i),
        .fire_o (fire)
    );

    win_fsm #(
        .MIN_DLY (MIN_DLY),
        .MAX_DLY (MAX_DLY),
        .TAIL_DLY(TAIL_DLY)
    ) u_fsm (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .mute_i(mute_i),
        .fire_i(fire),
        .hit_i (hit_i),
        .tail_i(tail_i),
        .fail_o(fail)
    );

    assign fail_o = fail;
    assign ok_o   = ~fail;

endmodule

// File: tb/test_win_monitor.sv
module test_win_monitor;

    localparam int AM = 2, AN = 4, AK = 2;
    localparam int BM = 3, BN = 3, BK = 1;
    localparam int LEN = 24;

    logic clk = 1'b0;
    logic rst, mute, cause, lead, hit, tail;
    logic fail_a, ok_a, fail_b, ok_b;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    win_monitor #(.MIN_DLY(AM), .MAX_DLY(AN), .TAIL_DLY(AK)) i_win_monitor (
        .clk_i(clk), .rst_i(rst), .mute_i(mute), .cause_i(cause), .lead_i(lead),
        .hit_i(hit), .tail_i(tail), .fail_o(fail_a), .ok_o(ok_a)
    );

    win_monitor #(.MIN_DLY(BM), .MAX_DLY(BN), .TAIL_DLY(BK)) i_win_monitor_fixed (
        .clk_i(clk), .rst_i(rst), .mute_i(mute), .cause_i(cause), .lead_i(lead),
        .hit_i(hit), .tail_i(tail), .fail_o(fail_b), .ok_o(ok_b)
    );

    task automatic check_vec(input string req, input logic [LEN-1:0] got,
                             input logic [LEN-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: pulse edges actual=%b expected=%b", req, got, exp);
        end
    endtask

    function automatic logic [LEN-1:0] exp_sweep(input int m, input int n, input int k,
                                                  input int d, input bit cv);
        logic [LEN-1:0] r;
        r = '0;
        if (d >= m && d <= n) begin
            if (!cv) r[d + k] = 1'b1;
        end else begin
            r[n] = 1'b1;
        end
        return r;
    endfunction

    // Drives one scenario; bit k of each mask is the input value at edge k
    task automatic run_case(input string req,
                            input logic [LEN-1:0] cause_m, input logic [LEN-1:0] lead_m,
                            input logic [LEN-1:0] hit_m,   input logic [LEN-1:0] tail_m,
                            input logic [LEN-1:0] mute_m,  input logic [LEN-1:0] rst_m,
                            input logic [LEN-1:0] exp_a,   input logic [LEN-1:0] exp_b);
        logic [LEN-1:0] hist_a, hist_b;
        bit inv_bad;
        hist_a = '0;
        hist_b = '0;
        inv_bad = 1'b0;
        for (int k = 0; k < LEN; k++) begin
            cause = cause_m[k];
            lead  = lead_m[k];
            hit   = hit_m[k];
            tail  = tail_m[k];
            mute  = mute_m[k];
            rst   = rst_m[k];
            @(negedge clk);
            hist_a[k] = fail_a;
            hist_b[k] = fail_b;
            if (ok_a !== ~fail_a || ok_b !== ~fail_b) inv_bad = 1'b1;
        end
        check_vec({req, " window"}, hist_a, exp_a);
        check_vec({req, " fixed"},  hist_b, exp_b);
        n_checks++;
        if (inv_bad) begin
            n_errors++;
            $display("FAIL R9: ok not inverse of fail, actual=mismatch expected=inverse");
        end
    endtask

    initial begin
        logic [LEN-1:0] one0, zero;
        one0 = 24'd1;
        zero = '0;
        rst = 1'b1; mute = 1'b0; cause = 1'b0; lead = 1'b0; hit = 1'b0; tail = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        n_checks++;
        if (fail_a !== 1'b0 || ok_a !== 1'b1 || fail_b !== 1'b0 || ok_b !== 1'b1) begin
            n_errors++;
            $display("FAIL R1: after reset fail=%b/%b ok=%b/%b expected fail=0 ok=1",
                     fail_a, fail_b, ok_a, ok_b);
        end

        // R3 R4 R5 R6: response at every offset, follow-up present and absent
        for (int d = 0; d <= 7; d++) begin
            for (int c = 0; c < 2; c++) begin
                logic [LEN-1:0] tm;
                tm = (c != 0) ? ((one0 << (d + 1)) | (one0 << (d + 2))) : zero;
                run_case($sformatf("R3/R4/R5/R6 d=%0d c=%0d", d, c),
                         one0, one0, one0 << d, tm, zero, zero,
                         exp_sweep(AM, AN, AK, d, c[0]),
                         exp_sweep(BM, BN, BK, d, c[0]));
            end
        end

        // R2: cause alone, lead alone
        run_case("R2 cause only", one0, zero, zero, zero, zero, zero, zero, zero);
        run_case("R2 lead only",  zero, one0, zero, zero, zero, zero, zero, zero);

        // R7: second start while busy is ignored
        run_case("R7 busy retrigger", one0 | (one0 << 2), one0 | (one0 << 2),
                 zero, zero, zero, zero, one0 << AN, one0 << BN);
        // R7: start after the attempt ended is accepted again
        run_case("R7 rearm", one0 | (one0 << 8), one0 | (one0 << 8), zero, zero, zero, zero,
                 (one0 << AN) | (one0 << (8 + AN)), (one0 << BN) | (one0 << (8 + BN)));

        // R8: mute and mid-run reset abandon the attempt
        run_case("R8 mute", one0, one0, zero, zero, one0 << 2, zero, zero, zero);
        run_case("R8 reset", one0, one0, zero, zero, zero, one0 << 1, zero, zero);
        // R8: a hit inside the window after mute produces nothing
        run_case("R8 mute then hit", one0, one0, one0 << 3, zero, one0 << 1, zero, zero, zero);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule